// File: doc/BRIEF.md
# Register-Mapped Free-Running ALU with AXI4-Lite Access

This block is an AXI4-Lite slave holding eight 32-bit words inside a 4 KB address window. Three of the words feed a small arithmetic unit: one selects the operation and two supply the operands. The unit recomputes its answer on every clock cycle and places it in two result words that the host can only read. Software uses it by writing an operation and operands with ordinary stores, then loading the results a few cycles later. There is no start bit and no done flag. The other three words are plain scratch storage.

Each word sits at byte offset 4*n, where n is the index 0..7 taken from address bits [4:2]. Address bits [1:0] are ignored. Offsets 0x020 through 0xFFC decode to nothing.

The write address and write data channels are accepted together, in one cycle, and only when both are valid and no write response is still pending. A response that is held back by `s_bready` low therefore stalls the next write. The read address channel is likewise blocked while read data waits on `s_rready`. Only one transaction per direction is ever in flight.

Top module: `axil_alu_regs`

## Requirements
- R1: After reset, reads of all eight words return 0, and both `s_bvalid` and `s_rvalid` are low.
- R2: A full-strobe write to words 0, 1, 2, 5, 6 or 7 reads back unchanged. For example, writing 42 to offset 0x000 reads back 0x0000002A.
- R3: A write updates only the bytes whose `s_wstrb` bit is set, with bit k covering data bits [8k+7:8k]. The other bytes keep their old contents.
- R4: Words 3 (result low) and 4 (result high) are read-only. Bus writes to offsets 0x00C and 0x010 leave their read values unchanged.
- R5: With opcode 0 (add), word 3 holds the 32-bit sum of word 1 and word 2, and word 4 holds the carry out (0 or 1).
- R6: With opcode 1 (subtract), word 3 holds word 1 minus word 2, and word 4 holds 1 when word 1 is less than word 2 (unsigned), otherwise 0.
- R7: With opcode 2 (multiply), the 64-bit unsigned product of words 1 and 2 is split, with the low half in word 3 and the high half in word 4.
- R8: Opcodes 3, 4 and 5 give the bitwise AND, OR and XOR of words 1 and 2 in word 3, with word 4 equal to 0.
- R9: Any other 32-bit opcode value, including values above 5 whose low three bits look valid, gives 0 in both result words.
- R10: Results follow the register contents without any trigger. They update on the clock edge after an operand or opcode write, so a read issued right after the write response already sees the new value.
- R11: Every write response and every read response carries the OKAY code, 2'b00.
- R12: `s_bvalid` stays high until `s_bready`. `s_rvalid` and `s_rdata` stay unchanged until `s_rready`. No new write is accepted while a write response is pending, and no new read is accepted while read data is pending.
- R13: Accesses to offsets 0x020 through 0xFFC complete with OKAY. Such writes change no word, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| s_awaddr | input | 12 | Write address (byte offset in window) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte enables for write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Host ready for write response |
| s_araddr | input | 12 | Read address (byte offset in window) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Host ready for read data |

## Verification
The assertions assume that the host obeys the handshake. Once it raises `s_awvalid`, `s_wvalid` or `s_arvalid`, it holds that signal and its payload until the matching ready is seen, and it never withdraws a request. Under that assumption they check response holding, the OKAY codes and the one-outstanding rule.

The stimulus stays within these rules. It drives one transaction at a time from tasks, presents the address and data channels together, and keeps them steady until accepted. It holds `s_bready` and `s_rready` low for random stretches so that the holding rules are actually exercised.

// File: rtl/alu_regs_pkg.sv
package alu_regs_pkg;
  // Word roles inside the register bank
  localparam int unsigned IDX_OP  = 0;
  localparam int unsigned IDX_A   = 1;
  localparam int unsigned IDX_B   = 2;
  localparam int unsigned IDX_LO  = 3;
  localparam int unsigned IDX_HI  = 4;

  // Operation codes held in the opcode word
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5
  } alu_op_e;

  localparam int unsigned OP_LAST = 5;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axil_alu_wr.sv
module axil_alu_wr #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     awaddr,
  input  logic                  awvalid,
  output logic                  awready,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   wstrb,
  input  logic                  wvalid,
  output logic                  wready,
  output logic [1:0]            bresp,
  output logic                  bvalid,
  input  logic                  bready,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W/8-1:0]   wr_strb
);
  import alu_regs_pkg::*;

  localparam int unsigned LSB_W = 2;
  localparam int unsigned HI_LO = IDX_W + LSB_W;

  logic bvalid_q;
  logic take;
  logic in_window;
  logic unused_lsbs;

  assign unused_lsbs = ^awaddr[LSB_W-1:0];

  // Address and data must arrive together; a pending response blocks both
  assign take      = awvalid && wvalid && !bvalid_q;
  assign awready   = take;
  assign wready    = take;
  assign in_window = (awaddr[ADDR_W-1:HI_LO] == '0);

  assign wr_en   = take && in_window;
  assign wr_idx  = awaddr[HI_LO-1:LSB_W];
  assign wr_data = wdata;
  assign wr_strb = wstrb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
    end else if (take) begin
      bvalid_q <= 1'b1;
    end else if (bready) begin
      bvalid_q <= 1'b0;
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;
endmodule

// File: rtl/axil_alu_rd.sv
module axil_alu_rd #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  araddr,
  input  logic               arvalid,
  output logic               arready,
  output logic [DATA_W-1:0]  rdata,
  output logic [1:0]         rresp,
  output logic               rvalid,
  input  logic               rready,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic [DATA_W-1:0]  rd_word
);
  import alu_regs_pkg::*;

  localparam int unsigned LSB_W = 2;
  localparam int unsigned HI_LO = IDX_W + LSB_W;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              take;
  logic              in_window;
  logic              unused_lsbs;

  assign unused_lsbs = ^araddr[LSB_W-1:0];

  assign arready   = !rvalid_q;
  assign take      = arvalid && !rvalid_q;
  assign in_window = (araddr[ADDR_W-1:HI_LO] == '0);
  assign rd_idx    = araddr[HI_LO-1:LSB_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (take) begin
      rvalid_q <= 1'b1;
      rdata_q  <= in_window ? rd_word : '0;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;
endmodule

// File: rtl/axil_alu_bank.sv
module axil_alu_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic [DATA_W/8-1:0]                wr_strb,
  input  logic [DATA_W-1:0]                  res_lo,
  input  logic [DATA_W-1:0]                  res_hi,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    words
);
  import alu_regs_pkg::*;

  localparam int unsigned BYTES = DATA_W / 8;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (i == IDX_LO) begin : g_lo
      assign words[i] = res_lo;
    end else if (i == IDX_HI) begin : g_hi
      assign words[i] = res_hi;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          for (int b = 0; b < BYTES; b++) begin
            if (wr_strb[b]) q[b*8 +: 8] <= wr_data[b*8 +: 8];
          end
        end
      end
      assign words[i] = q;
    end
  end
endmodule

// File: rtl/axil_alu_core.sv
module axil_alu_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi
);
  import alu_regs_pkg::*;

  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   sum;
  logic [DATA_W:0]   diff;
  logic [PROD_W-1:0] prod;
  logic              known;
  logic [DATA_W-1:0] nxt_lo;
  logic [DATA_W-1:0] nxt_hi;

  assign sum   = {1'b0, opa} + {1'b0, opb};
  assign diff  = {1'b0, opa} - {1'b0, opb};
  assign prod  = {{DATA_W{1'b0}}, opa} * {{DATA_W{1'b0}}, opb};
  // Whole word must match a defined code
  assign known = (opcode <= DATA_W'(OP_LAST));

  always_comb begin
    nxt_lo = '0;
    nxt_hi = '0;
    if (known) begin
      case (alu_op_e'(opcode[2:0]))
        OP_ADD: begin
          nxt_lo = sum[DATA_W-1:0];
          nxt_hi = DATA_W'(sum[DATA_W]);
        end
        OP_SUB: begin
          nxt_lo = diff[DATA_W-1:0];
          nxt_hi = DATA_W'(diff[DATA_W]);
        end
        OP_MUL: begin
          nxt_lo = prod[DATA_W-1:0];
          nxt_hi = prod[PROD_W-1:DATA_W];
        end
        OP_AND:  nxt_lo = opa & opb;
        OP_OR:   nxt_lo = opa | opb;
        OP_XOR:  nxt_lo = opa ^ opb;
        default: nxt_lo = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      res_lo <= nxt_lo;
      res_hi <= nxt_hi;
    end
  end
endmodule

// File: rtl/axil_alu_regs.sv
module axil_alu_regs #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                 aclk,
  input  logic                 aresetn,
  input  logic [ADDR_W-1:0]    s_awaddr,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [DATA_W-1:0]    s_wdata,
  input  logic [DATA_W/8-1:0]  s_wstrb,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  output logic [1:0]           s_bresp,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  input  logic [ADDR_W-1:0]    s_araddr,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  output logic [DATA_W-1:0]    s_rdata,
  output logic [1:0]           s_rresp,
  output logic                 s_rvalid,
  input  logic                 s_rready
);
  import alu_regs_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam int unsigned BYTES = DATA_W / 8;

  logic                            wr_en;
  logic [IDX_W-1:0]                wr_idx;
  logic [DATA_W-1:0]               wr_data;
  logic [BYTES-1:0]                wr_strb;
  logic [IDX_W-1:0]                rd_idx;
  logic [DATA_W-1:0]               rd_word;
  logic [DATA_W-1:0]               res_lo;
  logic [DATA_W-1:0]               res_hi;
  logic [NUM_REGS-1:0][DATA_W-1:0] words;

  axil_alu_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_wr (
    .clk     (aclk),
    .rst_n   (aresetn),
    .awaddr  (s_awaddr),
    .awvalid (s_awvalid),
    .awready (s_awready),
    .wdata   (s_wdata),
    .wstrb   (s_wstrb),
    .wvalid  (s_wvalid),
    .wready  (s_wready),
    .bresp   (s_bresp),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_strb (wr_strb)
  );

  axil_alu_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk     (aclk),
    .rst_n   (aresetn),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_strb (wr_strb),
    .res_lo  (res_lo),
    .res_hi  (res_hi),
    .words   (words)
  );

  axil_alu_core #(.DATA_W(DATA_W)) u_core (
    .clk    (aclk),
    .rst_n  (aresetn),
    .opcode (words[IDX_OP]),
    .opa    (words[IDX_A]),
    .opb    (words[IDX_B]),
    .res_lo (res_lo),
    .res_hi (res_hi)
  );

  assign rd_word = words[rd_idx];

  axil_alu_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
    .clk     (aclk),
    .rst_n   (aresetn),
    .araddr  (s_araddr),
    .arvalid (s_arvalid),
    .arready (s_arready),
    .rdata   (s_rdata),
    .rresp   (s_rresp),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );
endmodule

// File: rtl/axil_alu_regs_chk.sv
module axil_alu_regs_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              aclk,
  input logic              aresetn,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic [1:0]        s_bresp,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp,
  input logic              s_rvalid,
  input logic              s_rready
);
  // R12
  b_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid && !s_bready |=> s_bvalid);

  // R12
  r_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  // R11
  bresp_okay_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> s_bresp == 2'b00);

  // R11
  rresp_okay_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid |-> s_rresp == 2'b00);

  // R12
  one_wr_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> !s_awready && !s_wready);

  // R12
  one_rd_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid |-> !s_arready);

  // R12
  b_cause_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(s_bvalid) |-> $past(s_awvalid && s_awready && s_wvalid && s_wready));

  // R12
  r_cause_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(s_rvalid) |-> $past(s_arvalid && s_arready));
endmodule

bind axil_alu_regs axil_alu_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .aclk      (aclk),
  .aresetn   (aresetn),
  .s_awvalid (s_awvalid),
  .s_awready (s_awready),
  .s_wvalid  (s_wvalid),
  .s_wready  (s_wready),
  .s_bresp   (s_bresp),
  .s_bvalid  (s_bvalid),
  .s_bready  (s_bready),
  .s_arvalid (s_arvalid),
  .s_arready (s_arready),
  .s_rdata   (s_rdata),
  .s_rresp   (s_rresp),
  .s_rvalid  (s_rvalid),
  .s_rready  (s_rready)
);

// File: tb/sim_axil_alu_regs.sv
`timescale 1ns/1ps
module sim_axil_alu_regs;
  logic        clk = 1'b0;
  logic        rstn = 1'b0;
  logic [11:0] awaddr = '0;
  logic        awvalid = 1'b0;
  logic        awready;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        wvalid = 1'b0;
  logic        wready;
  logic [1:0]  bresp;
  logic        bvalid;
  logic        bready = 1'b0;
  logic [11:0] araddr = '0;
  logic        arvalid = 1'b0;
  logic        arready;
  logic [31:0] rdata;
  logic [1:0]  rresp;
  logic        rvalid;
  logic        rready = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] mdl [8];

  always #2.5 clk = ~clk;

  axil_alu_regs u0 (
    .aclk(clk), .aresetn(rstn),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [32:0] t;
    case (op)
      32'd0: begin t = {1'b0, a} + {1'b0, b}; return {31'b0, t[32], t[31:0]}; end
      32'd1: return {31'b0, (a < b), a - b};
      32'd2: return {32'b0, a} * {32'b0, b};
      32'd3: return {32'b0, a & b};
      32'd4: return {32'b0, a | b};
      32'd5: return {32'b0, a ^ b};
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] s);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (s[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                    input int hold);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    #0.5;
    while (!(awready && wready)) begin @(negedge clk); #0.5; end
    @(posedge clk); #0.5;
    awvalid = 1'b0; wvalid = 1'b0;
    @(negedge clk);
    chk("R12 bvalid after write", {31'b0, bvalid}, 32'd1);
    chk("R11 bresp", {30'b0, bresp}, 32'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R12 bvalid held", {31'b0, bvalid}, 32'd1);
    end
    bready = 1'b1;
    @(posedge clk); #0.5;
    bready = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input int hold, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    #0.5;
    while (!arready) begin @(negedge clk); #0.5; end
    @(posedge clk); #0.5;
    arvalid = 1'b0;
    @(negedge clk);
    chk("R12 rvalid after read", {31'b0, rvalid}, 32'd1);
    chk("R11 rresp", {30'b0, rresp}, 32'd0);
    d = rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R12 rvalid held", {31'b0, rvalid}, 32'd1);
      chk("R12 rdata held", rdata, d);
    end
    rready = 1'b1;
    @(posedge clk); #0.5;
    rready = 1'b0;
  endtask

  task automatic set_reg(input int idx, input logic [31:0] d);
    wr(12'(idx * 4), d, 4'hF, $urandom % 3);
    mdl[idx] = d;
  endtask

  task automatic check_results(input string req);
    logic [31:0] got;
    logic [63:0] e;
    e = model(mdl[0], mdl[1], mdl[2]);
    rd(12'h00C, $urandom % 2, got);
    chk({req, " low word"}, got, e[31:0]);
    rd(12'h010, $urandom % 2, got);
    chk({req, " high word"}, got, e[63:32]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 outputs idle during and right after reset
    chk("R1 bvalid in reset", {31'b0, bvalid}, 32'd0);
    chk("R1 rvalid in reset", {31'b0, rvalid}, 32'd0);
    rstn = 1'b1;
    @(negedge clk);
    chk("R1 bvalid after reset", {31'b0, bvalid}, 32'd0);
    chk("R1 rvalid after reset", {31'b0, rvalid}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(12'(i * 4), 0, got);
      chk("R1 reset word", got, 32'd0);
    end

    // R2 full word write and read back
    set_reg(0, 32'd42);
    rd(12'h000, 1, got);
    chk("R2 opcode word 42", got, 32'h0000002A);
    set_reg(5, 32'hDEADBEEF);
    set_reg(6, 32'h12345678);
    set_reg(7, 32'hA5A5_5A5A);
    rd(12'h014, 0, got); chk("R2 word5", got, 32'hDEADBEEF);
    rd(12'h018, 2, got); chk("R2 word6", got, 32'h12345678);
    rd(12'h01C, 0, got); chk("R2 word7", got, 32'hA5A5_5A5A);

    // R3 byte strobes
    wr(12'h014, 32'h11223344, 4'b0101, 0);
    mdl[5] = merge(mdl[5], 32'h11223344, 4'b0101);
    rd(12'h014, 0, got); chk("R3 strobe 0101", got, 32'hDE22BE44);
    wr(12'h018, 32'hFFFF_FFFF, 4'b0000, 0);
    rd(12'h018, 0, got); chk("R3 strobe none", got, 32'h12345678);
    wr(12'h01E, 32'hCAFE_0000, 4'b1000, 1);
    mdl[7] = merge(mdl[7], 32'hCAFE_0000, 4'b1000);
    rd(12'h01C, 0, got); chk("R3 strobe top byte", got, 32'hCAA5_5A5A);

    // R5 add with carry
    set_reg(1, 32'hFFFF_FFFF); set_reg(2, 32'd1); set_reg(0, 32'd0);
    rd(12'h00C, 0, got); chk("R5 add low", got, 32'd0);
    rd(12'h010, 0, got); chk("R5 add carry", got, 32'd1);
    set_reg(1, 32'd100); set_reg(2, 32'd23);
    check_results("R5 add no carry");

    // R4 result words ignore writes
    wr(12'h00C, 32'h5555_5555, 4'hF, 0);
    wr(12'h010, 32'h6666_6666, 4'hF, 0);
    rd(12'h00C, 0, got); chk("R4 low word read-only", got, 32'd123);
    rd(12'h010, 0, got); chk("R4 high word read-only", got, 32'd0);

    // R6 subtract with borrow
    set_reg(0, 32'd1); set_reg(1, 32'd1); set_reg(2, 32'd2);
    rd(12'h00C, 0, got); chk("R6 sub low", got, 32'hFFFF_FFFF);
    rd(12'h010, 0, got); chk("R6 sub borrow", got, 32'd1);
    set_reg(1, 32'd5); set_reg(2, 32'd3);
    check_results("R6 sub no borrow");

    // R7 multiply extremes
    set_reg(0, 32'd2); set_reg(1, 32'hFFFF_FFFF); set_reg(2, 32'hFFFF_FFFF);
    rd(12'h00C, 0, got); chk("R7 mul low", got, 32'h0000_0001);
    rd(12'h010, 0, got); chk("R7 mul high", got, 32'hFFFF_FFFE);

    // R8 logic ops
    set_reg(1, 32'hF0F0_1234); set_reg(2, 32'h0FF0_FF00);
    set_reg(0, 32'd3); check_results("R8 and");
    set_reg(0, 32'd4); check_results("R8 or");
    set_reg(0, 32'd5); check_results("R8 xor");

    // R9 unknown opcodes
    set_reg(0, 32'd6); check_results("R9 op 6");
    set_reg(0, 32'h0000_0100);
    rd(12'h00C, 0, got); chk("R9 op 0x100 low", got, 32'd0);
    rd(12'h010, 0, got); chk("R9 op 0x100 high", got, 32'd0);

    // R10 result follows an operand write without any trigger
    set_reg(0, 32'd0); set_reg(1, 32'd7); set_reg(2, 32'd8);
    wr(12'h004, 32'd1000, 4'hF, 0); mdl[1] = 32'd1000;
    rd(12'h00C, 0, got); chk("R10 immediate update", got, 32'd1008);

    // R13 offsets outside the eight words
    wr(12'h020, 32'h7777_7777, 4'hF, 0);
    wr(12'hFFC, 32'h8888_8888, 4'hF, 0);
    rd(12'h000, 0, got); chk("R13 alias write ignored", got, 32'd0);
    rd(12'h020, 0, got); chk("R13 read 0x020", got, 32'd0);
    rd(12'hFFC, 0, got); chk("R13 read 0xFFC", got, 32'd0);
    rd(12'h004, 0, got); chk("R13 operand intact", got, 32'd1000);

    // Random mix of operations and scratch writes (R5-R9, R3)
    for (int it = 0; it < 120; it++) begin
      int r;
      int ix;
      logic [31:0] d;
      logic [3:0] s;
      r = $urandom % 10;
      set_reg(1, ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom);
      set_reg(2, ($urandom % 4 == 0) ? 32'd0 : $urandom);
      set_reg(0, (r < 8) ? 32'(r) : $urandom);
      check_results("R5-R9 random");
      ix = 5 + ($urandom % 3);
      d = $urandom;
      s = 4'($urandom);
      wr(12'(ix * 4), d, s, $urandom % 2);
      mdl[ix] = merge(mdl[ix], d, s);
      rd(12'(ix * 4), 0, got);
      chk("R3 random strobe", got, mdl[ix]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule